// File: doc/BRIEF.md
# Real-Mode Segmented Address Translator

This block turns a 16-bit segment and a 16-bit offset into a 20-bit physical address, the way a real-mode processor does. It holds six 16-bit segment registers: code, stack, data and three extra registers. Software-visible logic upstream loads them through a simple write port. Each segment value marks the start of a 64 KB window inside a 1 MB space. The physical address is the segment shifted left by four bits plus the offset.

A translation request carries an offset and an access kind: instruction fetch, data or stack. The kind picks a default segment register. An optional override names any of the six registers and takes priority over the default. The extra registers are reached only through that override. The address appears on a registered output one clock after the request.

Top module: `segx_top`

## Requirements
- R1: While `rst` is high at a rising edge, `out_valid` and `phys_addr` go to 0 and all six segment registers go to 0. A request right after reset therefore returns its own offset.
- R2: A request presented with `req_valid` high at a rising edge gives `out_valid` high after that same edge. `phys_addr` then holds segment*16 + offset for the selected register.
- R3: Access kind 0 (instruction fetch) with no override uses segment register 0 (code).
- R4: Access kind 1 (data) with no override uses segment register 2 (data). Kind 3 is reserved and is handled the same as kind 1.
- R5: Access kind 2 (stack) with no override uses segment register 1 (stack).
- R6: When `ovr_valid` is high and `ovr_sel` is 0 to 5, the named register is used whatever the access kind. The numbering is 0 code, 1 stack, 2 data, 3 extra A, 4 extra B, 5 extra C.
- R7: When `ovr_valid` is high and `ovr_sel` is 6 or 7, the override is ignored and the default register for the access kind is used.
- R8: The sum is taken modulo 2^20. A carry out of bit 19 is dropped, so the address wraps within the 1 MB space.
- R9: A write with `wr_en` high at an edge loads `wr_data` into register `wr_sel` (numbered as in R6). A request at that same edge still sees the old value. Requests at later edges see the new value.
- R10: A write whose `wr_sel` is 6 or 7 changes no segment register.
- R11: An edge with `req_valid` low drives `out_valid` low, and `phys_addr` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Segment register write strobe |
| wr_sel | input | 3 | Register number to write (0..5 valid) |
| wr_data | input | 16 | New segment value |
| req_valid | input | 1 | Translation request strobe |
| req_kind | input | 2 | Access kind: 0 fetch, 1 data, 2 stack, 3 data |
| req_ofs | input | 16 | Offset within the segment |
| ovr_valid | input | 1 | Override present |
| ovr_sel | input | 3 | Override register number (0..5 valid) |
| out_valid | output | 1 | Registered result valid |
| phys_addr | output | 20 | Registered 20-bit physical address |

## Verification
All six registers are loaded with distinct values, so a request that picks the wrong register shows up as a wrong address. The table tries every access kind with no override, every legal override against kinds whose defaults differ from it, and the two illegal override codes. It also tries offsets of zero, all-ones and mid-range, so a missing shift or a truncated offset gives a visibly wrong sum. A data segment of 0xFFFF with a small offset checks that the carry past bit 19 is dropped. Directed steps check a write and a request at the same edge, writes to the unused register numbers, and idle cycles that must hold the last address.

// File: rtl/segx_pkg.sv
`timescale 1ns/1ps
package segx_pkg;

    localparam int SEG_W   = 16;
    localparam int OFS_W   = 16;
    localparam int SHIFT   = 4;
    localparam int PA_W    = SEG_W + SHIFT;
    localparam int NUM_SEG = 6;
    localparam int SEL_W   = $clog2(NUM_SEG + 2);
    localparam int KIND_W  = 2;

    typedef enum logic [KIND_W-1:0] {
        ACC_FETCH = 2'd0,
        ACC_DATA  = 2'd1,
        ACC_STACK = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [SEL_W-1:0] {
        SEG_CODE  = 3'd0,
        SEG_STACK = 3'd1,
        SEG_DATA  = 3'd2,
        SEG_XA    = 3'd3,
        SEG_XB    = 3'd4,
        SEG_XC    = 3'd5
    } seg_id_e;

    typedef struct packed {
        logic             valid;
        logic [OFS_W-1:0] ofs;
        logic [SEG_W-1:0] base;
    } xlat_req_t;

    typedef struct packed {
        logic            valid;
        logic [PA_W-1:0] addr;
    } xlat_rsp_t;

    // Default register implied by the kind of access.
    function automatic seg_id_e kind_default(input acc_kind_e kind);
        case (kind)
            ACC_FETCH: return SEG_CODE;
            ACC_STACK: return SEG_STACK;
            default:   return SEG_DATA;
        endcase
    endfunction

    function automatic logic sel_legal(input logic [SEL_W-1:0] sel);
        return (int'(sel) < NUM_SEG);
    endfunction

    // Shift-and-add, with the carry out of the top bit discarded.
    function automatic logic [PA_W-1:0] form_addr(input logic [SEG_W-1:0] base,
                                                   input logic [OFS_W-1:0] ofs);
        logic [PA_W:0] full;
        full = {1'b0, base, {SHIFT{1'b0}}} + (PA_W+1)'(ofs);
        return full[PA_W-1:0];
    endfunction

endpackage

// File: rtl/segx_regfile.sv
`timescale 1ns/1ps
module segx_regfile
    import segx_pkg::*;
#(
    parameter int N_REG = NUM_SEG,
    parameter int DW    = SEG_W,
    parameter int SW    = SEL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_sel,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] seg_q [N_REG]
);

    for (genvar g = 0; g < N_REG; g++) begin : g_reg
        localparam logic [SW-1:0] MY_ID = SW'(g);
        logic hit;
        assign hit = wr_en && (wr_sel == MY_ID);

        always_ff @(posedge clk) begin
            if (rst)      seg_q[g] <= '0;
            else if (hit) seg_q[g] <= wr_data;
        end

        // R9: a write lands in the addressed register at the next edge
        a_r9_write_lands: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_sel == MY_ID) |=> (seg_q[g] == $past(wr_data)));

        // R10: any other write, including to numbers 6 and 7, leaves this register alone
        a_r10_other_untouched: assert property (@(posedge clk) disable iff (rst)
            !(wr_en && wr_sel == MY_ID) |=> $stable(seg_q[g]));
    end

endmodule

// File: rtl/segx_pick.sv
`timescale 1ns/1ps
module segx_pick
    import segx_pkg::*;
#(
    parameter int SW = SEL_W
) (
    input  logic [KIND_W-1:0] kind,
    input  logic              ovr_valid,
    input  logic [SW-1:0]     ovr_sel,
    output logic [SW-1:0]     pick
);

    acc_kind_e kind_e;
    seg_id_e   dflt;
    logic      use_ovr;

    always_comb begin
        kind_e  = acc_kind_e'(kind);
        dflt    = kind_default(kind_e);
        use_ovr = ovr_valid && sel_legal(ovr_sel);
        pick    = use_ovr ? ovr_sel : SW'(dflt);
    end

    always_comb begin
        assert (int'(pick) < NUM_SEG);
    end

endmodule

// File: rtl/segx_stage.sv
`timescale 1ns/1ps
module segx_stage
    import segx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  xlat_req_t req,
    output xlat_rsp_t rsp
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp <= '0;
        end else begin
            rsp.valid <= req.valid;
            if (req.valid) rsp.addr <= form_addr(req.base, req.ofs);
        end
    end

    // R11: an idle edge clears valid and keeps the address
    a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !req.valid |=> (!rsp.valid && $stable(rsp.addr)));

endmodule

// File: rtl/segx_top.sv
`timescale 1ns/1ps
module segx_top
    import segx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [SEG_W-1:0]  wr_data,
    input  logic              req_valid,
    input  logic [KIND_W-1:0] req_kind,
    input  logic [OFS_W-1:0]  req_ofs,
    input  logic              ovr_valid,
    input  logic [SEL_W-1:0]  ovr_sel,
    output logic              out_valid,
    output logic [PA_W-1:0]   phys_addr
);

    logic [SEG_W-1:0] seg_q [NUM_SEG];
    logic [SEL_W-1:0] pick;
    logic [SEG_W-1:0] base;
    xlat_req_t        req;
    xlat_rsp_t        rsp;

    segx_regfile #(.N_REG(NUM_SEG), .DW(SEG_W), .SW(SEL_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .seg_q(seg_q)
    );

    segx_pick #(.SW(SEL_W)) u_pick (
        .kind(req_kind), .ovr_valid(ovr_valid), .ovr_sel(ovr_sel), .pick(pick)
    );

    always_comb begin
        base = '0;
        for (int i = 0; i < NUM_SEG; i++) begin
            if (pick == SEL_W'(i)) base = seg_q[i];
        end
        req.valid = req_valid;
        req.ofs   = req_ofs;
        req.base  = base;
    end

    segx_stage u_stage (.clk(clk), .rst(rst), .req(req), .rsp(rsp));

    assign out_valid = rsp.valid;
    assign phys_addr = rsp.addr;

    // R2: one-cycle latency of the valid flag
    a_r2_valid_next: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_valid);

    // R3: fetch without override uses register 0
    a_r3_fetch_code: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == 2'd0 && !ovr_valid) |=>
        (phys_addr == (PA_W'({$past(seg_q[0]), {SHIFT{1'b0}}}) + PA_W'($past(req_ofs)))));

    // R4: data without override uses register 2
    a_r4_data_seg: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == 2'd1 && !ovr_valid) |=>
        (phys_addr == (PA_W'({$past(seg_q[2]), {SHIFT{1'b0}}}) + PA_W'($past(req_ofs)))));

    // R5: stack without override uses register 1
    a_r5_stack_seg: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == 2'd2 && !ovr_valid) |=>
        (phys_addr == (PA_W'({$past(seg_q[1]), {SHIFT{1'b0}}}) + PA_W'($past(req_ofs)))));

    // R6: a legal override names the register used
    a_r6_override: assert property (@(posedge clk) disable iff (rst)
        (req_valid && ovr_valid && int'(ovr_sel) < NUM_SEG) |=>
        (phys_addr == (PA_W'({$past(base), {SHIFT{1'b0}}}) + PA_W'($past(req_ofs)))));

endmodule

// File: tb/segx_top_test.sv
`timescale 1ns/1ps
module segx_top_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [2:0]  wr_sel;
    logic [15:0] wr_data;
    logic        req_valid;
    logic [1:0]  req_kind;
    logic [15:0] req_ofs;
    logic        ovr_valid;
    logic [2:0]  ovr_sel;
    logic        out_valid;
    logic [19:0] phys_addr;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [15:0] model [6];

    always #2 clk = ~clk;

    segx_top uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .req_valid(req_valid), .req_kind(req_kind), .req_ofs(req_ofs),
        .ovr_valid(ovr_valid), .ovr_sel(ovr_sel),
        .out_valid(out_valid), .phys_addr(phys_addr)
    );

    typedef struct packed {
        logic [1:0]  kind;
        logic        ov;
        logic [2:0]  osel;
        logic [15:0] ofs;
        logic [2:0]  exp_reg;
        logic [3:0]  tag;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t TBL [NV] = '{
        '{2'd0, 1'b0, 3'd0, 16'h0000, 3'd0, 4'd3},   // R3 fetch, zero offset
        '{2'd0, 1'b0, 3'd0, 16'hFFFF, 3'd0, 4'd3},   // R3 fetch, full offset
        '{2'd1, 1'b0, 3'd0, 16'h0123, 3'd2, 4'd4},   // R4 data (wraps, data=FFFF)
        '{2'd3, 1'b0, 3'd0, 16'h0001, 3'd2, 4'd4},   // R4 reserved kind acts as data
        '{2'd2, 1'b0, 3'd0, 16'h7FFE, 3'd1, 4'd5},   // R5 stack
        '{2'd0, 1'b1, 3'd1, 16'h0040, 3'd1, 4'd6},   // R6 fetch forced to stack
        '{2'd2, 1'b1, 3'd0, 16'h0040, 3'd0, 4'd6},   // R6 stack forced to code
        '{2'd1, 1'b1, 3'd3, 16'h1111, 3'd3, 4'd6},   // R6 extra A
        '{2'd1, 1'b1, 3'd4, 16'hABCD, 3'd4, 4'd6},   // R6 extra B
        '{2'd0, 1'b1, 3'd5, 16'h8000, 3'd5, 4'd6},   // R6 extra C
        '{2'd2, 1'b1, 3'd2, 16'h0002, 3'd2, 4'd6},   // R6 stack forced to data
        '{2'd0, 1'b1, 3'd6, 16'h0010, 3'd0, 4'd7},   // R7 illegal override ignored
        '{2'd2, 1'b1, 3'd7, 16'h0010, 3'd1, 4'd7},   // R7 illegal override ignored
        '{2'd1, 1'b0, 3'd0, 16'h0020, 3'd2, 4'd8}    // R8 FFFF0+20 wraps to 00010
    };

    function automatic logic [19:0] expect_addr(input logic [15:0] s, input logic [15:0] o);
        int unsigned v;
        v = int'(s) * 16 + int'(o);
        return 20'(v % 1048576);
    endfunction

    task automatic check(input int tag, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL R%0d %s actual=%h expected=%h", tag, what, got, exp);
        end
    endtask

    task automatic idle_inputs();
        wr_en = 0; wr_sel = 0; wr_data = 0;
        req_valid = 0; req_kind = 0; req_ofs = 0; ovr_valid = 0; ovr_sel = 0;
    endtask

    task automatic seg_write(input logic [2:0] sel, input logic [15:0] val);
        @(negedge clk);
        idle_inputs();
        wr_en = 1; wr_sel = sel; wr_data = val;
        if (sel < 6) model[sel] = val;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic request(input logic [1:0] kind, input logic ov, input logic [2:0] osel,
                           input logic [15:0] ofs);
        @(negedge clk);
        idle_inputs();
        req_valid = 1; req_kind = kind; ovr_valid = ov; ovr_sel = osel; req_ofs = ofs;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog (all requirements) actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst = 1;
        for (int i = 0; i < 6; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1: outputs cleared in reset
        check(1, "out_valid in reset", 32'(out_valid), 32'd0);
        check(1, "phys_addr in reset", 32'(phys_addr), 32'd0);
        @(negedge clk);
        rst = 0;

        // R1: cleared registers make the address equal the offset
        request(2'd1, 1'b1, 3'd4, 16'h5A5A);
        check(1, "post-reset extra B address", 32'(phys_addr), 32'h05A5A);
        check(2, "out_valid one cycle after request", 32'(out_valid), 32'd1);

        seg_write(3'd0, 16'h1234);
        seg_write(3'd1, 16'h2000);
        seg_write(3'd2, 16'hFFFF);
        seg_write(3'd3, 16'h0ABC);
        seg_write(3'd4, 16'h8001);
        seg_write(3'd5, 16'h0010);

        // R2..R8: table walk
        for (int k = 0; k < NV; k++) begin
            request(TBL[k].kind, TBL[k].ov, TBL[k].osel, TBL[k].ofs);
            check(int'(TBL[k].tag), $sformatf("vector %0d address", k), 32'(phys_addr),
                  32'(expect_addr(model[TBL[k].exp_reg], TBL[k].ofs)));
            check(2, $sformatf("vector %0d valid", k), 32'(out_valid), 32'd1);
        end

        // R8: explicit wrap value
        request(2'd1, 1'b0, 3'd0, 16'h0020);
        check(8, "wrap of FFFF:0020", 32'(phys_addr), 32'h00010);

        // R11: idle edge clears valid and holds the address
        @(negedge clk);
        idle_inputs();
        req_ofs = 16'h3333;
        @(posedge clk); #1;
        check(11, "idle valid", 32'(out_valid), 32'd0);
        check(11, "idle address held", 32'(phys_addr), 32'h00010);

        // R9: write and request at the same edge see the old value
        @(negedge clk);
        idle_inputs();
        wr_en = 1; wr_sel = 3'd2; wr_data = 16'h0500;
        req_valid = 1; req_kind = 2'd1; req_ofs = 16'h0004;
        @(posedge clk); #1;
        check(9, "same-edge request uses old data seg", 32'(phys_addr),
              32'(expect_addr(16'hFFFF, 16'h0004)));
        model[2] = 16'h0500;
        @(negedge clk);
        wr_en = 0;
        @(posedge clk); #1;
        check(9, "next-edge request uses new data seg", 32'(phys_addr), 32'h05004);

        // R10: writes to numbers 6 and 7 touch nothing
        seg_write(3'd6, 16'h7777);
        seg_write(3'd7, 16'h9999);
        for (int r = 0; r < 6; r++) begin
            request(2'd0, 1'b1, 3'(r), 16'h0001);
            check(10, $sformatf("register %0d after bad-number writes", r), 32'(phys_addr),
                  32'(expect_addr(model[r], 16'h0001)));
        end

        // R1: reset again clears all registers
        @(negedge clk);
        idle_inputs();
        rst = 1;
        @(negedge clk);
        rst = 0;
        request(2'd0, 1'b0, 3'd0, 16'h0042);
        check(1, "code seg cleared by reset", 32'(phys_addr), 32'h00042);

        @(negedge clk);
        idle_inputs();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule